// File: doc/BRIEF.md
# Network Controller Interrupt Cause and Mask Unit

This block gathers interrupt requests for a network controller. Each hardware event pulse sets a sticky bit in a cause register. Software reaches the block through a simple register port. A read of the cause register returns every pending cause and empties the register in the same access. A write-only set register lets software raise causes itself. Two separate registers change the enable mask: one sets mask bits and the other clears them.

One registered, level-sensitive interrupt line is high while at least one pending cause is also enabled. Bit 31 of the cause value is a summary flag that copies that line. Bits 30:0 are the individual sources.

The named sources are:
- bit 0: transmit descriptor written back
- bit 2: link status change
- bit 3: receive sequence error
- bit 4: receive descriptor minimum threshold
- bit 7: receive timer

All other bits up to 30 can be used for further sources.

Top module: `nic_irq_ctrl`

## Requirements
- R1: After reset the cause register and the mask are all zero, irq_o is low, and reads of the cause (0x0C0) and mask (0x0D0) offsets return 0.
- R2: A high evt_in[i] in a clock cycle sets cause bit i at that cycle's closing edge. The bit then stays set until a clearing read of the cause register.
- R3: A read of offset 0x0C0 returns the cause bits in reg_rdata[30:0] and the current irq_o in bit 31, in the same cycle. At the closing edge of that cycle it clears all cause bits.
- R4: An event pulse in the same cycle as a clearing read leaves its cause bit set after the read.
- R5: A write to offset 0x0C8 sets every cause bit 30:0 whose wdata bit is 1 and leaves the other cause bits alone. A read of 0x0C8 returns 0.
- R6: A write to offset 0x0D0 sets every mask bit whose wdata bit is 1 and leaves the other mask bits unchanged. A read of 0x0D0 returns the mask in bits 30:0, with bit 31 at 0.
- R7: A write to offset 0x0D8 clears every mask bit whose wdata bit is 1, so writing all ones disables every source. A read of 0x0D8 returns 0.
- R8: irq_o is registered. In each cycle it equals whether (cause AND mask) was nonzero in the previous cycle, so it drops one cycle after the clearing read.
- R9: The mask has no effect on the cause register. A masked cause is still recorded and still read back.
- R10: A write to 0x0C0 or to any offset other than 0x0C8, 0x0D0 and 0x0D8 changes no state. A read of any offset other than 0x0C0 and 0x0D0 returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid in the cycle reg_rd is high |
| evt_in | input | DATA_W-1 | Hardware event pulses, one per cause bit 30:0 |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- a clearing read with no concurrent event or set empties the cause register;
- causes never drop without a clearing read;
- event bits always land in the cause register;
- mask set and clear writes touch only their selected bits;
- the mask holds when no mask write occurs;
- irq_o follows the pending term one cycle late.

The bench's scenarios show the rest:
- the read values themselves;
- the summary bit;
- events that coincide with a clearing read;
- the all-ones disable;
- that masked causes survive;
- that writes and reads at unused offsets have no effect.

// File: rtl/nic_irq_pkg.sv
package nic_irq_pkg;
  localparam int DATA_W = 32;
  localparam int SRC_W  = DATA_W - 1;

  localparam logic [15:0] OFS_CAUSE   = 16'h00C0;
  localparam logic [15:0] OFS_SET     = 16'h00C8;
  localparam logic [15:0] OFS_MASKSET = 16'h00D0;
  localparam logic [15:0] OFS_MASKCLR = 16'h00D8;

  localparam int SRC_TX_WRITEBACK = 0;
  localparam int SRC_LINK_CHANGE  = 2;
  localparam int SRC_RX_SEQ_ERR   = 3;
  localparam int SRC_RX_LOW_DESC  = 4;
  localparam int SRC_RX_TIMER     = 7;

  function automatic logic [SRC_W-1:0] cause_step(
    input logic [SRC_W-1:0] cur,
    input logic             clr,
    input logic [SRC_W-1:0] evt,
    input logic             sw_set,
    input logic [SRC_W-1:0] sw_val);
    logic [SRC_W-1:0] kept;
    kept = clr ? '0 : cur;
    return kept | evt | (sw_set ? sw_val : '0);
  endfunction

  function automatic logic mask_bit_step(
    input logic cur, input logic set_en, input logic clr_en, input logic val);
    if (set_en && val) return 1'b1;
    if (clr_en && val) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/nic_irq_cause.sv
module nic_irq_cause
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_clr,
  input  logic             sw_set,
  input  logic [SRC_W-1:0] sw_val,
  input  logic [SRC_W-1:0] evt,
  output logic [SRC_W-1:0] cause_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) cause_q <= '0;
    else        cause_q <= cause_step(cause_q, rd_clr, evt, sw_set, sw_val);
  end

  a_r3_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (evt == '0) && !sw_set) |=> (cause_q == '0));

  a_r2_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((cause_q & $past(evt)) == $past(evt)));

  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask
  import nic_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [SRC_W-1:0] val,
  output logic [SRC_W-1:0] mask_q
);
  for (genvar i = 0; i < SRC_W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q[i] <= 1'b0;
      else        mask_q[i] <= mask_bit_step(mask_q[i], set_en, clr_en, val[i]);
    end
  end

  a_r6_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> ((mask_q & $past(val)) == $past(val)));

  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> ((mask_q & $past(val)) == '0));

  a_r6_others_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_en && !clr_en) |=> $stable(mask_q));
endmodule

// File: rtl/nic_irq_out.sv
module nic_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic pending,
  output logic irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

  a_r8_rises: assert property (@(posedge clk) disable iff (!rst_n)
    pending |=> irq_q);

  a_r8_falls: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |=> !irq_q);
endmodule

// File: rtl/nic_irq_ctrl.sv
module nic_irq_ctrl
  import nic_irq_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [SRC_W-1:0]  evt_in,
  output logic              irq_o
);
  logic [SRC_W-1:0] cause_w, mask_w;
  logic pend_w;
  logic sel_cause, sel_set, sel_mset, sel_mclr;
  logic rd_clr_w, sw_set_w, mset_w, mclr_w;
  logic unused_wbit;

  assign unused_wbit = reg_wdata[DATA_W-1];

  assign sel_cause = (reg_addr == OFS_CAUSE[ADDR_W-1:0]);
  assign sel_set   = (reg_addr == OFS_SET[ADDR_W-1:0]);
  assign sel_mset  = (reg_addr == OFS_MASKSET[ADDR_W-1:0]);
  assign sel_mclr  = (reg_addr == OFS_MASKCLR[ADDR_W-1:0]);

  assign rd_clr_w = reg_rd && sel_cause;
  assign sw_set_w = reg_wr && sel_set;
  assign mset_w   = reg_wr && sel_mset;
  assign mclr_w   = reg_wr && sel_mclr;

  nic_irq_cause u_cause (
    .clk(clk), .rst_n(rst_n), .rd_clr(rd_clr_w), .sw_set(sw_set_w),
    .sw_val(reg_wdata[SRC_W-1:0]), .evt(evt_in), .cause_q(cause_w));

  nic_irq_mask u_mask (
    .clk(clk), .rst_n(rst_n), .set_en(mset_w), .clr_en(mclr_w),
    .val(reg_wdata[SRC_W-1:0]), .mask_q(mask_w));

  assign pend_w = |(cause_w & mask_w);

  nic_irq_out u_out (.clk(clk), .rst_n(rst_n), .pending(pend_w), .irq_q(irq_o));

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (sel_cause)     reg_rdata = {irq_o, cause_w};
      else if (sel_mset) reg_rdata = {1'b0, mask_w};
    end
  end

  a_r3_summary_bit: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr_w |-> (reg_rdata[DATA_W-1] == irq_o));

  a_r10_quiet_read: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && !sel_cause && !sel_mset) |-> (reg_rdata == '0));
endmodule

// File: tb/sim_nic_irq_ctrl.sv
`timescale 1ns/100ps
module sim_nic_irq_ctrl;
  localparam int DW = 32;
  localparam int SW = 31;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_rd = 1'b0, reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic [SW-1:0] evt_in = '0;
  logic irq_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [SW-1:0] m_cause, m_mask;
  logic m_irq;

  always #2.5 clk = ~clk;

  nic_irq_ctrl #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .evt_in(evt_in), .irq_o(irq_o));

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
    if (a == 12'h0C0) return {m_irq, m_cause};
    if (a == 12'h0D0) return {1'b0, m_mask};
    return '0;
  endfunction

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                      input logic [DW-1:0] wd, input logic [SW-1:0] ev, input string tag);
    logic nirq;
    logic [SW-1:0] nc, nm;
    @(negedge clk);
    check("R8 irq level", {31'd0, irq_o}, {31'd0, m_irq});
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; evt_in = ev;
    #1;
    if (rd) check(tag, reg_rdata, exp_read(a));
    @(posedge clk);
    nirq = |(m_cause & m_mask);
    nc = ((rd && a == 12'h0C0) ? '0 : m_cause) | ev | ((wr && a == 12'h0C8) ? wd[SW-1:0] : '0);
    nm = m_mask;
    if (wr && a == 12'h0D0) nm = nm | wd[SW-1:0];
    if (wr && a == 12'h0D8) nm = nm & ~wd[SW-1:0];
    m_cause = nc; m_mask = nm; m_irq = nirq;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, '0, '0, '0, "idle");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 7;
    void'($urandom(seed));
    m_cause = '0; m_mask = '0; m_irq = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset state
    step(1'b1, 1'b0, 12'h0C0, '0, '0, "R1 cause after reset");
    step(1'b1, 1'b0, 12'h0D0, '0, '0, "R1 mask after reset");
    // R2 event, R9 masked still recorded
    step(1'b0, 1'b0, '0, '0, 31'h80, "R2 event");
    idle();
    step(1'b1, 1'b0, 12'h0C0, '0, '0, "R9 masked cause read");
    // R6 enable, R5 software set, R8 irq rises, R3 summary bit
    step(1'b0, 1'b1, 12'h0D0, 32'h0000_0084, '0, "R6 mask set");
    step(1'b0, 1'b1, 12'h0C8, 32'hFFFF_FF04, '0, "R5 sw set");
    idle(); idle();
    step(1'b1, 1'b0, 12'h0D0, '0, '0, "R6 mask read");
    step(1'b1, 1'b0, 12'h0C8, '0, '0, "R5 set reads zero");
    // R4 event during clearing read
    step(1'b1, 1'b0, 12'h0C0, '0, 31'h4, "R3 read with summary");
    step(1'b1, 1'b0, 12'h0C0, '0, '0, "R4 event kept");
    idle(); idle();
    // R10 ignored writes
    step(1'b0, 1'b1, 12'h0C0, 32'hFFFF_FFFF, '0, "R10 write cause addr");
    step(1'b0, 1'b1, 12'h0E0, 32'hFFFF_FFFF, '0, "R10 write other");
    step(1'b1, 1'b0, 12'h0C0, '0, '0, "R10 cause unchanged");
    step(1'b1, 1'b0, 12'h0D0, '0, '0, "R10 mask unchanged");
    step(1'b1, 1'b0, 12'h0E0, '0, '0, "R10 other read zero");
    // R7 disable all
    step(1'b0, 1'b1, 12'h0D0, 32'h7FFF_FFFF, '0, "R6 all on");
    step(1'b0, 1'b1, 12'h0D8, 32'hFFFF_FFFF, '0, "R7 all off");
    step(1'b1, 1'b0, 12'h0D0, '0, '0, "R7 mask cleared");
    step(1'b1, 1'b0, 12'h0D8, '0, '0, "R7 clr reads zero");
    // random traffic
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [SW-1:0] ev;
      logic [DW-1:0] wd;
      op = int'($urandom % 16);
      ev = SW'($urandom & $urandom & $urandom);
      wd = $urandom;
      case (op)
        0, 1, 2: step(1'b1, 1'b0, 12'h0C0, '0, ev, "R3 random cause read");
        3:       step(1'b1, 1'b0, 12'h0D0, '0, ev, "R6 random mask read");
        4:       step(1'b1, 1'b0, 12'h0D8, '0, ev, "R7 random clr read");
        5:       step(1'b1, 1'b0, 12'h0C8, '0, ev, "R5 random set read");
        6, 7:    step(1'b0, 1'b1, 12'h0D0, wd & $urandom, ev, "R6 random set");
        8:       step(1'b0, 1'b1, 12'h0D8, wd, ev, "R7 random clear");
        9:       step(1'b0, 1'b1, 12'h0C8, wd & $urandom & $urandom, ev, "R5 random sw set");
        10:      step(1'b0, 1'b1, 12'h0C0, wd, ev, "R10 random cause write");
        11:      step(1'b0, 1'b1, AW'($urandom), wd, ev, "R10 random addr write");
        12:      step(1'b1, 1'b0, AW'($urandom), '0, ev, "R10 random addr read");
        default: step(1'b0, 1'b0, '0, '0, ev, "R2 events only");
      endcase
    end
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule